// File: doc/BRIEF.md
# Servo Position PWM Generator

The block drives one hobby servo by producing a pulse train at roughly 47 Hz from a 50 MHz clock. The high time of each pulse sets the servo angle. A prescaler makes a fixed time base (1 µs by default). A frame counter runs on that time base and sets the pulse repetition period. The pulse width is given in time-base ticks. It comes from a target register, which can be loaded with an absolute position or moved up and down in fixed steps.

The target is always kept inside the servo's calibrated travel. The two end stops and the power-up centre are parameters, given in tenths of a percent of the frame. They default to 4.2 %, 7.0 % and 9.8 %. A servo with different calibration needs only new parameter values, and a second axis needs only a second instance. The value that drives the comparator is copied from the target once per frame, at the frame boundary. A command that arrives mid-pulse therefore never shortens or stretches the pulse already in progress.

Top module: `servo_pwm`

## Requirements
- R1: While reset is active and at its release, the target and the active width hold the centre value (FRAME_TICKS*CTR_PM/1000 ticks). `pwm_o` is high, and the first pulse after release lasts exactly the centre width.
- R2: The pulse period is FRAME_TICKS = TICK_HZ/FRAME_HZ ticks of CLK_HZ/TICK_HZ clocks each. Every frame boundary raises `pwm_o` on the next clock.
- R3: Each pulse stays high for (active width in ticks) × (CLK_HZ/TICK_HZ) clock cycles. The target and the active width never leave [MIN, MAX].
- R4: A cycle with `load_i` high and `pos_i` inside [MIN, MAX] sets the target to `pos_i` (in ticks) on the next edge.
- R5: A load with `pos_i` below MIN stores MIN. A load with `pos_i` above MAX stores MAX.
- R6: A cycle with `inc_i` high (and no load, no decrement) adds STEP_TICKS to the target. The result saturates at MAX.
- R7: A cycle with `dec_i` high (and no load, no increment) subtracts STEP_TICKS from the target. The result saturates at MIN and never wraps.
- R8: `load_i` takes priority over the step inputs. `inc_i` and `dec_i` high together leave the target unchanged.
- R9: The active width changes only at a frame boundary, where it takes the target's value. A command given while a pulse is high does not change that pulse; it shows on the following one.
- R10: MIN = FRAME_TICKS*MIN_PM/1000, MAX = FRAME_TICKS*MAX_PM/1000, with defaults MIN_PM=42, CTR_PM=70, MAX_PM=98.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (CLK_HZ) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | DW | Absolute pulse width in ticks, used with `load_i` |
| load_i | input | 1 | Load strobe for `pos_i` |
| inc_i | input | 1 | Step target up by STEP_TICKS |
| dec_i | input | 1 | Step target down by STEP_TICKS |
| pwm_o | output | 1 | Servo pulse output |

## Verification
The bound checker watches the target and active-width registers on every cycle. It checks the following:
- the range bound;
- the exact result of in-range loads and low clamps;
- saturation on both step directions;
- cancellation of simultaneous steps;
- the rule that the active width moves only at a frame boundary, together with the rising pulse that follows each boundary.

Pulse widths and periods measured in clock cycles are shown only by the bench scenarios:
- the centre width after reset;
- the effect of the high clamp;
- the load-over-step priority as seen at the pin;
- the pulse that is already high being unchanged while the next pulse carries the new value.

// File: rtl/servo_pkg.sv
package servo_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD,
    CMD_LOAD,
    CMD_INC,
    CMD_DEC
  } duty_cmd_e;

  // load wins; opposing steps cancel
  function automatic duty_cmd_e decode_cmd(input logic load, input logic inc, input logic dec);
    if (load)            return CMD_LOAD;
    else if (inc && !dec) return CMD_INC;
    else if (dec && !inc) return CMD_DEC;
    else                 return CMD_HOLD;
  endfunction

endpackage

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/servo_duty_acc.sv
module servo_duty_acc
  import servo_pkg::*;
#(
  parameter int DW   = 15,
  parameter int DMIN = 893,
  parameter int DCTR = 1489,
  parameter int DMAX = 2085,
  parameter int STEP = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [DW-1:0] pos_i,
  output logic [DW-1:0] tgt_o
);
  localparam logic [DW-1:0] MIN_V  = DW'(DMIN);
  localparam logic [DW-1:0] CTR_V  = DW'(DCTR);
  localparam logic [DW-1:0] MAX_V  = DW'(DMAX);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);
  localparam logic [DW:0]   STEP_W = (DW+1)'(STEP);

  logic [DW-1:0] tgt_q, tgt_d;
  logic [DW:0]   up_sum;
  duty_cmd_e     cmd;

  assign cmd    = decode_cmd(load_i, inc_i, dec_i);
  assign up_sum = {1'b0, tgt_q} + STEP_W;

  always_comb begin
    tgt_d = tgt_q;
    unique case (cmd)
      CMD_LOAD: begin
        if (pos_i < MIN_V)      tgt_d = MIN_V;
        else if (pos_i > MAX_V) tgt_d = MAX_V;
        else                    tgt_d = pos_i;
      end
      CMD_INC: tgt_d = (up_sum > {1'b0, MAX_V}) ? MAX_V : tgt_q + STEP_V;
      CMD_DEC: tgt_d = ({1'b0, tgt_q} < ({1'b0, MIN_V} + STEP_W)) ? MIN_V : tgt_q - STEP_V;
      default: tgt_d = tgt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgt_q <= CTR_V;
    else         tgt_q <= tgt_d;
  end

  assign tgt_o = tgt_q;
endmodule

// File: rtl/servo_frame.sv
module servo_frame #(
  parameter int DW          = 15,
  parameter int FRAME_TICKS = 21276,
  parameter int DCTR        = 1489
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] tgt_i,
  output logic          frame_start_o,
  output logic [DW-1:0] act_o,
  output logic          pwm_o
);
  localparam logic [DW-1:0] LAST  = DW'(FRAME_TICKS - 1);
  localparam logic [DW-1:0] CTR_V = DW'(DCTR);

  logic [DW-1:0] pos_q, pos_d, act_q, act_d;
  logic          pwm_q;

  assign frame_start_o = tick_i && (pos_q == LAST);

  always_comb begin
    pos_d = pos_q;
    if (frame_start_o) pos_d = '0;
    else if (tick_i)   pos_d = pos_q + 1'b1;
    // width is taken only on the wrap, so a pulse in flight is never altered
    act_d = frame_start_o ? tgt_i : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      act_q <= CTR_V;
      pwm_q <= (DCTR > 0);
    end else begin
      pos_q <= pos_d;
      act_q <= act_d;
      pwm_q <= (pos_d < act_d);
    end
  end

  assign act_o = act_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/servo_pwm.sv
module servo_pwm #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TICK_HZ    = 1_000_000,
  parameter int FRAME_HZ   = 47,
  parameter int MIN_PM     = 42,
  parameter int CTR_PM     = 70,
  parameter int MAX_PM     = 98,
  parameter int STEP_TICKS = 10,
  localparam int FRAME_TICKS = TICK_HZ / FRAME_HZ,
  localparam int DW          = $clog2(FRAME_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pos_i,
  input  logic          load_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic          pwm_o
);
  localparam int DIV  = CLK_HZ / TICK_HZ;
  localparam int DMIN = FRAME_TICKS * MIN_PM / 1000;
  localparam int DCTR = FRAME_TICKS * CTR_PM / 1000;
  localparam int DMAX = FRAME_TICKS * MAX_PM / 1000;

  logic          tick;
  logic          frame_start;
  logic [DW-1:0] tgt_duty;
  logic [DW-1:0] act_duty;

  servo_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  servo_duty_acc #(
    .DW(DW), .DMIN(DMIN), .DCTR(DCTR), .DMAX(DMAX), .STEP(STEP_TICKS)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .inc_i  (inc_i),
    .dec_i  (dec_i),
    .pos_i  (pos_i),
    .tgt_o  (tgt_duty)
  );

  servo_frame #(
    .DW(DW), .FRAME_TICKS(FRAME_TICKS), .DCTR(DCTR)
  ) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .tgt_i         (tgt_duty),
    .frame_start_o (frame_start),
    .act_o         (act_duty),
    .pwm_o         (pwm_o)
  );
endmodule

// File: rtl/servo_pwm_chk.sv
module servo_pwm_chk #(
  parameter int DW   = 15,
  parameter int DMIN = 893,
  parameter int DMAX = 2085,
  parameter int STEP = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          inc_i,
  input logic          dec_i,
  input logic [DW-1:0] pos_i,
  input logic [DW-1:0] tgt,
  input logic [DW-1:0] act,
  input logic          frame_start,
  input logic          pwm_o
);
  p_tgt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tgt) >= DMIN && int'(tgt) <= DMAX && int'(act) >= DMIN && int'(act) <= DMAX);

  p_frame_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> pwm_o);

  p_load_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && int'(pos_i) >= DMIN && int'(pos_i) <= DMAX) |=> tgt == $past(pos_i));

  p_clamp_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && int'(pos_i) < DMIN) |=> int'(tgt) == DMIN);

  p_inc_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i && !dec_i && int'(tgt) + STEP > DMAX) |=> int'(tgt) == DMAX);

  p_dec_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dec_i && !inc_i && int'(tgt) < DMIN + STEP) |=> int'(tgt) == DMIN);

  p_step_cancel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i && dec_i) |=> $stable(tgt));

  p_act_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(act));

  p_act_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> act == $past(tgt));
endmodule

bind servo_pwm servo_pwm_chk #(
  .DW(DW), .DMIN(DMIN), .DMAX(DMAX), .STEP(STEP_TICKS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .inc_i       (inc_i),
  .dec_i       (dec_i),
  .pos_i       (pos_i),
  .tgt         (tgt_duty),
  .act         (act_duty),
  .frame_start (frame_start),
  .pwm_o       (pwm_o)
);

// File: tb/sim_servo_pwm.sv
module sim_servo_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ   = 2000;
  localparam int TICK_HZ  = 1000;
  localparam int FRAME_HZ = 1;
  localparam int STEP     = 5;
  localparam int DIV      = CLK_HZ / TICK_HZ;
  localparam int FTICKS   = TICK_HZ / FRAME_HZ;
  localparam int DW       = $clog2(FTICKS + 1);
  localparam int E_MIN    = FTICKS * 42 / 1000;
  localparam int E_CTR    = FTICKS * 70 / 1000;
  localparam int E_MAX    = FTICKS * 98 / 1000;
  localparam int WATCHDOG = 190_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] pos = '0;
  logic          load = 1'b0, inc = 1'b0, dec = 1'b0;
  logic          pwm;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_pwm #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .FRAME_HZ(FRAME_HZ),
    .MIN_PM(42), .CTR_PM(70), .MAX_PM(98), .STEP_TICKS(STEP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pos_i(pos),
    .load_i(load), .inc_i(inc), .dec_i(dec), .pwm_o(pwm)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // return at the first low sample after a pulse: early in the low phase
  task automatic sync_fall();
    while (!pwm) @(negedge clk);
    while (pwm) @(negedge clk);
  endtask

  task automatic measure_next(output int n);
    n = 0;
    while (!pwm) @(negedge clk);
    while (pwm) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_load(input int v, input logic with_inc);
    pos = DW'(v); load = 1'b1; inc = with_inc;
    @(negedge clk);
    load = 1'b0; inc = 1'b0;
  endtask

  task automatic do_step(input logic up, input logic down, input int times);
    for (int i = 0; i < times; i++) begin
      inc = up; dec = down;
      @(negedge clk);
    end
    inc = 1'b0; dec = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    check("R1 pwm high in reset", int'(pwm), 1);
    rst_n = 1'b1;
    n = 0;
    while (pwm) begin
      n++;
      @(negedge clk);
    end
    check("R1 first pulse centre width", n, E_CTR * DIV);
  endtask

  task automatic t_period();
    int n;
    logic prev;
    while (!pwm) @(negedge clk);
    n = 0; prev = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (pwm && !prev) break;
      prev = pwm;
    end
    check("R2 frame period clocks", n, FTICKS * DIV);
  endtask

  task automatic t_load_in();
    int n;
    sync_fall(); do_load(60, 1'b0); measure_next(n);
    check("R4 R3 in-range load width", n, 60 * DIV);
  endtask

  task automatic t_clamp();
    int n;
    sync_fall(); do_load(10, 1'b0); measure_next(n);
    check("R5 R10 low clamp", n, E_MIN * DIV);
    sync_fall(); do_load(900, 1'b0); measure_next(n);
    check("R5 R10 high clamp", n, E_MAX * DIV);
  endtask

  task automatic t_inc();
    int n;
    sync_fall(); do_load(60, 1'b0); do_step(1'b1, 1'b0, 1); measure_next(n);
    check("R6 single increment", n, (60 + STEP) * DIV);
    sync_fall(); do_load(E_MAX - 2, 1'b0); do_step(1'b1, 1'b0, 1); measure_next(n);
    check("R6 increment saturates", n, E_MAX * DIV);
    sync_fall(); do_step(1'b1, 1'b0, 8); measure_next(n);
    check("R6 repeated increment at max", n, E_MAX * DIV);
  endtask

  task automatic t_dec();
    int n;
    sync_fall(); do_load(60, 1'b0); do_step(1'b0, 1'b1, 1); measure_next(n);
    check("R7 single decrement", n, (60 - STEP) * DIV);
    sync_fall(); do_load(E_MIN + 2, 1'b0); do_step(1'b0, 1'b1, 1); measure_next(n);
    check("R7 decrement saturates", n, E_MIN * DIV);
    sync_fall(); do_step(1'b0, 1'b1, 20); measure_next(n);
    check("R7 no wrap below min", n, E_MIN * DIV);
  endtask

  task automatic t_prio();
    int n;
    sync_fall(); do_load(70, 1'b1); measure_next(n);
    check("R8 load beats increment", n, 70 * DIV);
    sync_fall(); do_step(1'b1, 1'b1, 4); measure_next(n);
    check("R8 opposing steps cancel", n, 70 * DIV);
  endtask

  task automatic t_frame_only();
    int n;
    logic prev;
    prev = pwm;
    forever begin
      @(negedge clk);
      if (pwm && !prev) break;
      prev = pwm;
    end
    // pulse at 70 ticks is high now; load a new width mid-pulse
    n = 1;
    pos = DW'(E_MAX); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    while (pwm) begin
      n++;
      @(negedge clk);
    end
    check("R9 pulse in flight unchanged", n, 70 * DIV);
    measure_next(n);
    check("R9 new width next frame", n, E_MAX * DIV);
  endtask

  initial begin
    t_reset();
    t_period();
    t_load_in();
    t_clamp();
    t_inc();
    t_dec();
    t_prio();
    t_frame_only();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule